// File: doc/BRIEF.md
# Serial Channel-Enable Latch with Frame Validation

This block receives a serial command stream for an eight-channel output driver and holds the resulting on/off pattern in an output latch. While the select line is low, each rising edge of the serial clock shifts the data line into a shift register, most significant bit first. The bit at the top of that register is presented on the serial output, so several devices can be wired in a chain: a longer frame passes through each stage, and each stage keeps the last eight bits it received.

When the select line rises, the block checks how many serial clock pulses arrived during the window. Only a non-zero multiple of eight moves the shift register into the channel latch. Any other count drops the command. An active-low disable input clears the shift register, the clock count and the latch at once, without waiting for a clock edge. The channels stay off after the disable is released, until a new valid frame has been written.

The serial pins are oversampled by a fast system clock through synchronizer stages. For this reason the serial clock must be several system clocks slower than the system clock.

Top module: `spi_out_latch_ctrl`

## Requirements
- R1: With select low, each rising serial clock edge shifts the data line into bit 0 and moves the older bits toward the top. After an eight-clock frame, ch_en[7] holds the first bit sent and ch_en[0] holds the last.
- R2: After select falls, and after each falling serial clock edge while selected, so carries the top bit (bit 7) of the shift register. In a frame longer than eight clocks, so replays the bits received eight clocks earlier.
- R3: so_oe is 1 while select is low and 0 while it is high, each after the synchronizer delay.
- R4: While select is high, the serial clock and data lines have no effect on the shift register, the count or the latch.
- R5: A rising select edge loads the latch from the shift register when the clock count is 8, 16, 24 or any other non-zero multiple of eight. The latch then holds the last eight bits received.
- R6: A rising select edge after 0 clocks, or after any count that is not a multiple of eight, leaves ch_en unchanged.
- R7: dis_n low forces ch_en to all zeros without a clock edge. It also clears the shift register and the clock count.
- R8: Once dis_n returns high, ch_en stays zero until a valid frame commits. Only clocks that arrive after the release count toward that frame.
- R9: After reset, ch_en is all zeros and so_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, idle high |
| cs_n | input | 1 | Active-low select for the frame window |
| si | input | 1 | Serial data in, most significant bit first |
| dis_n | input | 1 | Asynchronous active-low disable of all channels |
| so | output | 1 | Serial data out for chaining |
| so_oe | output | 1 | Enable for the so driver |
| ch_en | output | 8 | Latched channel on/off pattern, 1 = on |

## Verification
The bench sends every one of the 256 byte values as an eight-clock frame. It then sweeps every frame length from zero to twenty-five clocks, so that any rule other than "non-zero multiple of eight" is caught. Such a rule would latch a seven-clock or nine-clock frame, or latch garbage after a select pulse with no clocks. The bench checks the serial output at every clock, which catches a shifter that drops or reorders bits in a chain, and a one-bit misalignment of the latch. It toggles the clock and data lines while deselected and then reads the register back through the serial output, which exposes a shifter that is not gated by select. It also asserts the disable in the middle of a frame, which exposes two faults: a design that keeps pre-disable clocks in its count, and one that restores the old pattern after release.

// File: rtl/spi_latch_pkg.sv
package spi_latch_pkg;

  // Increment with wrap at a modulus.
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned m);
    return (v + 1 == m) ? 0 : v + 1;
  endfunction

  // A window is valid only when clocks were seen and the wrapped count is zero.
  function automatic logic accept_frame(input logic seen, input int unsigned v);
    return seen && (v == 0);
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int N = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0][STAGES-1:0] chain;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= {STAGES{RST_VAL[g]}};
      else        chain[g] <= {chain[g][STAGES-2:0], d[g]};
    end
    assign q[g] = chain[g][STAGES-1];
  end
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
  import spi_latch_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_n,
  input  logic         cs_s,
  input  logic         sclk_s,
  input  logic         si_s,
  output logic [W-1:0] shreg_o,
  output logic         so_o,
  output logic         oe_o,
  output logic         commit_o,
  output logic         cs_fall_o
);
  localparam int CW = $clog2(W);

  logic          cs_d, sclk_d, oe_q;
  logic [W-1:0]  sh_q;
  logic [CW-1:0] cnt_q;
  logic          seen_q, so_q;

  // Edge events on the synchronized pins
  logic cs_rise, cs_fall, sclk_rise, sclk_fall;
  assign cs_rise   =  cs_s & ~cs_d;
  assign cs_fall   = ~cs_s &  cs_d;
  assign sclk_rise =  sclk_s & ~sclk_d & ~cs_s;
  assign sclk_fall = ~sclk_s &  sclk_d & ~cs_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d   <= 1'b1;
      sclk_d <= 1'b1;
      oe_q   <= 1'b0;
    end else begin
      cs_d   <= cs_s;
      sclk_d <= sclk_s;
      if (cs_fall)      oe_q <= 1'b1;
      else if (cs_rise) oe_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      seen_q <= 1'b0;
      so_q   <= 1'b0;
    end else begin
      if (cs_rise || cs_fall) begin
        cnt_q  <= '0;
        seen_q <= 1'b0;
      end
      if (cs_fall) so_q <= sh_q[W-1];
      if (sclk_rise) begin
        sh_q   <= {sh_q[W-2:0], si_s};
        cnt_q  <= CW'(wrap_inc(32'(cnt_q), W));
        seen_q <= 1'b1;
      end
      if (sclk_fall) so_q <= sh_q[W-1];
    end
  end

  assign commit_o  = cs_rise && accept_frame(seen_q, 32'(cnt_q));
  assign cs_fall_o = cs_fall;
  assign shreg_o   = sh_q;
  assign so_o      = so_q;
  assign oe_o      = oe_q;
endmodule

// File: rtl/spi_chan_latch.sv
module spi_chan_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/spi_out_latch_ctrl.sv
module spi_out_latch_ctrl #(
  parameter int WIDTH = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             si,
  input  logic             dis_n,
  output logic             so,
  output logic             so_oe,
  output logic [WIDTH-1:0] ch_en
);
  logic             cs_s, sclk_s, si_s;
  logic             clr_n;
  logic [WIDTH-1:0] shreg_w;
  logic             commit_w, cs_fall_w;

  assign clr_n = rst_n & dis_n;

  spi_pin_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({cs_n, sclk, si}),
    .q    ({cs_s, sclk_s, si_s})
  );

  spi_frame_shifter #(.W(WIDTH)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_n    (clr_n),
    .cs_s     (cs_s),
    .sclk_s   (sclk_s),
    .si_s     (si_s),
    .shreg_o  (shreg_w),
    .so_o     (so),
    .oe_o     (so_oe),
    .commit_o (commit_w),
    .cs_fall_o(cs_fall_w)
  );

  spi_chan_latch #(.W(WIDTH)) u_latch (
    .clk  (clk),
    .clr_n(clr_n),
    .load (commit_w),
    .d    (shreg_w),
    .q    (ch_en)
  );
endmodule

// File: rtl/spi_out_latch_ctrl_chk.sv
module spi_out_latch_ctrl_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         dis_n,
  input logic         so,
  input logic         so_oe,
  input logic [W-1:0] ch_en,
  input logic [W-1:0] shreg,
  input logic         cs_s,
  input logic         commit_ev,
  input logic         cs_fall_ev
);
  p_dis_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dis_n |-> ch_en == '0);

  p_commit_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(commit_ev) && $past(dis_n) && dis_n) |-> ch_en == $past(shreg));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_n && $past(dis_n) && !$past(commit_ev)) |-> $stable(ch_en));

  p_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_n && $past(dis_n) && $past(cs_s)) |-> $stable(shreg));

  p_so_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs_fall_ev) && $past(dis_n) && dis_n) |-> so == $past(shreg[W-1]));

  p_oe_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(so_oe) |-> $past(cs_fall_ev));

  p_oe_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(so_oe) |-> $past(cs_s));
endmodule

bind spi_out_latch_ctrl spi_out_latch_ctrl_chk #(.W(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dis_n     (dis_n),
  .so        (so),
  .so_oe     (so_oe),
  .ch_en     (ch_en),
  .shreg     (shreg_w),
  .cs_s      (cs_s),
  .commit_ev (commit_w),
  .cs_fall_ev(cs_fall_w)
);

// File: tb/tb_spi_out_latch_ctrl.sv
module tb_spi_out_latch_ctrl;
  localparam int W = 8;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1, cs_n = 1'b1, si = 1'b0, dis_n = 1'b1;
  logic so, so_oe;
  logic [W-1:0] ch_en;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [W-1:0] exp_sh = '0;
  logic [W-1:0] exp_en = '0;
  int           exp_cnt = 0;

  always #5 clk = ~clk;

  spi_out_latch_ctrl #(.WIDTH(W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .si(si),
    .dis_n(dis_n), .so(so), .so_oe(so_oe), .ch_en(ch_en)
  );

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic begin_frame();
    cs_n = 1'b0;
    exp_cnt = 0;
    cyc(HALF);
    chk(so_oe, 1, "R3", "so_oe after select");
    chk(so, exp_sh[W-1], "R2", "so after select");
  endtask

  task automatic clk_bit(input logic b);
    sclk = 1'b0;
    si = b;
    cyc(HALF);
    chk(so, exp_sh[W-1], "R2", "so after falling sclk");
    sclk = 1'b1;
    cyc(HALF);
    exp_sh = {exp_sh[W-2:0], b};
    exp_cnt++;
  endtask

  task automatic end_frame(input string req);
    cs_n = 1'b1;
    cyc(HALF + 2);
    if (exp_cnt > 0 && exp_cnt % W == 0) exp_en = exp_sh;
    chk(ch_en, exp_en, req, "ch_en after frame");
    chk(so_oe, 0, "R3", "so_oe after deselect");
  endtask

  task automatic send(input logic [31:0] data, input int n, input string req);
    begin_frame();
    for (int i = n - 1; i >= 0; i--) clk_bit(data[i]);
    end_frame(req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(4);
    chk(ch_en, 0, "R9", "ch_en in reset");
    chk(so_oe, 0, "R9", "so_oe in reset");
    rst_n = 1'b1;
    cyc(4);
    chk(ch_en, 0, "R9", "ch_en after reset");

    // R1: every byte value as an 8-clock frame
    for (int v = 0; v < 256; v++) send(32'(v), 8, "R1");

    // R5/R6: every length 0..25 with a fixed pattern
    for (int n = 0; n <= 25; n++) begin
      if (n % 8 == 0 && n > 0) send(32'h01A5_C3E7 ^ 32'(n), n, "R5");
      else                     send(32'h01A5_C3E7 ^ 32'(n), n, "R6");
    end
    send(32'h5A, 8, "R1");
    send(32'h7F, 7, "R6");
    send(32'h1FF, 9, "R6");
    send(32'h0, 0, "R6");
    send(32'hABCD, 16, "R5");
    send(32'h12_3456, 24, "R5");

    // R4: toggles while deselected, then read back through so
    for (int i = 0; i < 5; i++) begin
      sclk = 1'b0; si = i[0]; cyc(HALF);
      sclk = 1'b1; cyc(HALF);
    end
    chk(ch_en, exp_en, "R4", "ch_en after deselected toggles");
    send(32'h3C, 8, "R4");

    // R7/R8: disable mid-frame, then three more clocks (rejected)
    begin_frame();
    for (int i = 0; i < 5; i++) clk_bit(1'b1);
    dis_n = 1'b0;
    #1;
    chk(ch_en, 0, "R7", "ch_en during disable");
    exp_sh = '0; exp_cnt = 0; exp_en = '0;
    cyc(3);
    dis_n = 1'b1;
    cyc(3);
    for (int i = 0; i < 3; i++) clk_bit(1'b1);
    end_frame("R8");
    chk(ch_en, 0, "R8", "channels stay off after release");

    // R8: disable mid-frame, then a full eight clocks after release (accepted)
    send(32'hF0, 8, "R1");
    begin_frame();
    for (int i = 0; i < 3; i++) clk_bit(1'b0);
    dis_n = 1'b0;
    #1;
    chk(ch_en, 0, "R7", "ch_en cleared asynchronously");
    exp_sh = '0; exp_cnt = 0; exp_en = '0;
    cyc(3);
    dis_n = 1'b1;
    cyc(3);
    for (int i = 7; i >= 0; i--) clk_bit(8'h96 >> i);
    end_frame("R8");
    chk(ch_en, 8'h96, "R8", "valid frame after release");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule